// File: doc/BRIEF.md
# Clock Mode and Divider Controller

This block produces the enable that paces a CPU core. It sits in the fast clock domain, where the multiplied clock is modelled as the block clock and each edge of the reference clock is modelled as a one-cycle strobe. A two-bit mode input chooses how the enable is built from these sources: pass the reference through, halve it, or run at the full multiplied rate.

The multiplied rate is only used once it is known to be stable. A lock counter counts reference edges while the device is out of reset. Until 256 edges have been counted, the multiplied mode produces half the reference rate. When the count completes, the source changes to the fast clock at the end of a whole output period. The lock status stays set until power-on reset, so later device resets do not repeat the slow phase.

On top of the chosen source, a divider set by the CPU selects full speed, one pulse per sixteen source pulses, or a full stop. A new setting waits for the current output period to finish. The stop state is left when any interrupt line goes low or when the device reset goes low. A device reset also returns the divider to full speed.

Top module: `clk_mode_ctrl`

## Requirements
- R1: With `mode_sel` 2'b00 (static pass-through) or 2'b10 (direct), the divider at full speed gives exactly one `cpu_ce` pulse per `ref_tick`.
- R2: With `mode_sel` 2'b01 (halved), `cpu_ce` pulses once per two `ref_tick` strobes. A falling `rst_pin_n` realigns the halving: the first strobe after the fall gives no pulse and the second gives one.
- R3: With `mode_sel` 2'b11 (multiplied) and the lock not yet complete, `cpu_ce` runs at half the `ref_tick` rate.
- R4: The lock counter advances only on a `ref_tick` seen while `rst_pin_n` is high and `mode_sel` is 2'b11. `lock_done` is 0 out of power-on reset and rises the cycle after the 256th counted strobe.
- R5: Once `lock_done` is set, multiplied mode changes to the fast source at the end of a half-rate period. After that, at full speed, `cpu_ce` is high every cycle.
- R6: `lock_done` stays set through later device resets, and multiplied mode runs fast right after such a reset.
- R7: `div_load` captures `div_sel`, encoded 2'b00 full speed, 2'b01 one-sixteenth, 2'b10 stop. One-sixteenth gives one `cpu_ce` per 16 source pulses.
- R8: A divider change takes effect only at the end of a complete output period. When leaving one-sixteenth, the 16-pulse count in progress finishes first.
- R9: In the stop state `cpu_ce` stays low.
- R10: Any `irq_n` line low in the stop state returns the divider to full speed.
- R11: `rst_pin_n` low puts the divider at full speed, cancels a pending change, leaves stop, and causes `div_load` to be ignored while it is low.
- R12: `div_sel` 2'b11 is ignored, and `div_load` has no effect in the stop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (multiplied) clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; the only reset that clears the lock status |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| mode_sel | input | 2 | Source mode: 00 static, 01 halved, 10 direct, 11 multiplied |
| rst_pin_n | input | 1 | Device reset, active low, synchronous to `clk` |
| irq_n | input | NUM_IRQ | Interrupt lines, active low, used for wake from stop |
| div_load | input | 1 | Strobe that captures `div_sel` |
| div_sel | input | 2 | Divider request: 00 full, 01 one-sixteenth, 10 stop, 11 ignored |
| cpu_ce | output | 1 | Registered CPU clock enable |
| lock_done | output | 1 | Lock counter has completed |

## Verification
The main function is driven from a vector table. The table crosses each source mode with full speed and with one-sixteenth, and every window it measures is a whole number of output periods. Because the windows are whole periods, the pulse count separates pass-through, halved, multiplied and divided rates exactly. Separate sequences drive the lock ramp, with reset held low first and then released, and compare `lock_done` against a counted model on every cycle. The reset realignment of the halved clock is tried from two opposite starting phases, so a design that does not clear the phase fails at least one of them. A change request placed just after a one-sixteenth pulse shows whether the change waits the full 16 pulses. Stop is woken once by an interrupt and once by reset, and a load during reset and a reserved code are each shown to leave the output rate unchanged.

// File: rtl/clkm_pkg.sv
package clkm_pkg;

    typedef enum logic [1:0] {
        DIV_FULL = 2'd0,
        DIV_SLOW = 2'd1,
        DIV_STOP = 2'd2
    } div_state_e;

    typedef enum logic {
        SRC_HALF = 1'b0,
        SRC_FAST = 1'b1
    } src_state_e;

    localparam logic [1:0] MODE_STATIC = 2'b00;
    localparam logic [1:0] MODE_HALVED = 2'b01;
    localparam logic [1:0] MODE_DIRECT = 2'b10;
    localparam logic [1:0] MODE_MULT   = 2'b11;

    localparam logic [1:0] SEL_FULL = 2'b00;
    localparam logic [1:0] SEL_SLOW = 2'b01;
    localparam logic [1:0] SEL_STOP = 2'b10;

endpackage

// File: rtl/clkm_lock_ctr.sv
module clkm_lock_ctr #(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ref_tick,
    input  logic              count_en,
    output logic [LOCK_W-1:0] lock_cnt,
    output logic              lock_done
);
    localparam logic [LOCK_W-1:0] CNT_ONE  = LOCK_W'(1);
    localparam logic [LOCK_W-1:0] CNT_LAST = {LOCK_W{1'b1}};

    // Counts reference strobes once; power-on reset is the only clear.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock_cnt  <= '0;
            lock_done <= 1'b0;
        end else if (count_en && ref_tick && !lock_done) begin
            lock_cnt <= lock_cnt + CNT_ONE;
            if (lock_cnt == CNT_LAST) begin
                lock_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkm_src_sel.sv
module clkm_src_sel
    import clkm_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       ref_tick,
    input  logic       rst_fall,
    input  logic [1:0] mode_sel,
    input  logic       lock_done,
    output logic       base_ce,
    output src_state_e src_state
);
    logic       half_ph;
    logic       half_ce;
    src_state_e src_next;

    // Halving phase: a falling device reset puts it back to its first half.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            half_ph <= 1'b0;
        end else if (rst_fall) begin
            half_ph <= 1'b0;
        end else if (ref_tick) begin
            half_ph <= ~half_ph;
        end
    end

    always_comb begin
        src_next = src_state;
        unique case (src_state)
            SRC_HALF: if (lock_done && !half_ph) src_next = SRC_FAST;
            SRC_FAST: src_next = SRC_FAST;
            default:  src_next = SRC_HALF;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            src_state <= SRC_HALF;
        end else begin
            src_state <= src_next;
        end
    end

    assign half_ce = ref_tick & half_ph;

    always_comb begin
        base_ce = 1'b0;
        unique case (mode_sel)
            MODE_STATIC: base_ce = ref_tick;
            MODE_HALVED: base_ce = half_ce;
            MODE_DIRECT: base_ce = ref_tick;
            MODE_MULT:   base_ce = (src_state == SRC_FAST) ? 1'b1 : half_ce;
            default:     base_ce = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkm_divider.sv
module clkm_divider
    import clkm_pkg::*;
#(
    parameter int SLOW_DIV = 16,
    parameter int NUM_IRQ  = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               base_ce,
    input  logic               rst_pin_n,
    input  logic [NUM_IRQ-1:0] irq_n,
    input  logic               div_load,
    input  logic [1:0]         div_sel,
    output logic               cpu_ce,
    output div_state_e         div_state
);
    localparam int              DIV_W    = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);

    div_state_e       div_next;
    logic [DIV_W-1:0] slow_cnt;
    logic             pend_v;
    logic [1:0]       pend_sel;
    logic             boundary;
    logic             wake;
    logic             sel_ok;
    logic             ce_next;

    assign wake   = !rst_pin_n || !(&irq_n);
    assign sel_ok = (div_sel == SEL_FULL) || (div_sel == SEL_SLOW) || (div_sel == SEL_STOP);

    function automatic div_state_e sel_to_state(input logic [1:0] sel, input div_state_e cur);
        div_state_e st;
        st = cur;
        unique case (sel)
            SEL_FULL: st = DIV_FULL;
            SEL_SLOW: st = DIV_SLOW;
            SEL_STOP: st = DIV_STOP;
            default:  st = cur;
        endcase
        return st;
    endfunction

    // End of a complete output period in each state.
    always_comb begin
        boundary = 1'b0;
        unique case (div_state)
            DIV_FULL: boundary = 1'b1;
            DIV_SLOW: boundary = base_ce && (slow_cnt == DIV_LAST);
            DIV_STOP: boundary = 1'b0;
            default:  boundary = 1'b1;
        endcase
    end

    always_comb begin
        div_next = div_state;
        if (!rst_pin_n) begin
            div_next = DIV_FULL;
        end else begin
            unique case (div_state)
                DIV_FULL: if (pend_v && boundary) div_next = sel_to_state(pend_sel, div_state);
                DIV_SLOW: if (pend_v && boundary) div_next = sel_to_state(pend_sel, div_state);
                DIV_STOP: if (wake) div_next = DIV_FULL;
                default:  div_next = DIV_FULL;
            endcase
        end
    end

    // State register with its period counter and pending request.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            div_state <= DIV_FULL;
            slow_cnt  <= '0;
            pend_v    <= 1'b0;
            pend_sel  <= SEL_FULL;
        end else begin
            div_state <= div_next;
            if (!rst_pin_n) begin
                pend_v <= 1'b0;
            end else if (div_load && sel_ok && div_state != DIV_STOP) begin
                pend_v   <= 1'b1;
                pend_sel <= div_sel;
            end else if (pend_v && boundary) begin
                pend_v <= 1'b0;
            end
            if (div_next != div_state || !rst_pin_n) begin
                slow_cnt <= '0;
            end else if (div_state == DIV_SLOW && base_ce) begin
                slow_cnt <= (slow_cnt == DIV_LAST) ? '0 : slow_cnt + DIV_ONE;
            end
        end
    end

    always_comb begin
        ce_next = 1'b0;
        unique case (div_state)
            DIV_FULL: ce_next = base_ce;
            DIV_SLOW: ce_next = base_ce && (slow_cnt == DIV_LAST);
            DIV_STOP: ce_next = 1'b0;
            default:  ce_next = 1'b0;
        endcase
    end

    // Output register.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cpu_ce <= 1'b0;
        end else begin
            cpu_ce <= ce_next;
        end
    end

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import clkm_pkg::*;
#(
    parameter int LOCK_W   = 8,
    parameter int SLOW_DIV = 16,
    parameter int NUM_IRQ  = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ref_tick,
    input  logic [1:0]         mode_sel,
    input  logic               rst_pin_n,
    input  logic [NUM_IRQ-1:0] irq_n,
    input  logic               div_load,
    input  logic [1:0]         div_sel,
    output logic               cpu_ce,
    output logic               lock_done
);
    logic              rst_q;
    logic              rst_fall;
    logic              lock_en;
    logic              base_ce;
    logic [LOCK_W-1:0] lock_cnt;
    src_state_e        src_state;
    div_state_e        div_state;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_q <= 1'b0;
        end else begin
            rst_q <= rst_pin_n;
        end
    end

    assign rst_fall = rst_q & ~rst_pin_n;
    assign lock_en  = rst_pin_n && (mode_sel == MODE_MULT);

    clkm_lock_ctr #(
        .LOCK_W (LOCK_W)
    ) lock_i (
        .clk       (clk),
        .por_n     (por_n),
        .ref_tick  (ref_tick),
        .count_en  (lock_en),
        .lock_cnt  (lock_cnt),
        .lock_done (lock_done)
    );

    clkm_src_sel src_i (
        .clk       (clk),
        .por_n     (por_n),
        .ref_tick  (ref_tick),
        .rst_fall  (rst_fall),
        .mode_sel  (mode_sel),
        .lock_done (lock_done),
        .base_ce   (base_ce),
        .src_state (src_state)
    );

    clkm_divider #(
        .SLOW_DIV (SLOW_DIV),
        .NUM_IRQ  (NUM_IRQ)
    ) div_i (
        .clk       (clk),
        .por_n     (por_n),
        .base_ce   (base_ce),
        .rst_pin_n (rst_pin_n),
        .irq_n     (irq_n),
        .div_load  (div_load),
        .div_sel   (div_sel),
        .cpu_ce    (cpu_ce),
        .div_state (div_state)
    );

endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk
    import clkm_pkg::*;
#(
    parameter int LOCK_W  = 8,
    parameter int NUM_IRQ = 4
) (
    input logic               clk,
    input logic               por_n,
    input logic               rst_pin_n,
    input logic [NUM_IRQ-1:0] irq_n,
    input logic               cpu_ce,
    input logic               lock_done,
    input div_state_e         div_state,
    input logic [LOCK_W-1:0]  lock_cnt
);
    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!por_n)
        (div_state == DIV_STOP) |=> !cpu_ce);

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
        lock_done |=> lock_done);

    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> $stable(lock_cnt));

    assert_wake_irq_R10: assert property (@(posedge clk) disable iff (!por_n)
        (div_state == DIV_STOP && !(&irq_n)) |=> (div_state == DIV_FULL));

    assert_rst_full_R11: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> (div_state == DIV_FULL));

endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk #(
    .LOCK_W  (LOCK_W),
    .NUM_IRQ (NUM_IRQ)
) chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .rst_pin_n (rst_pin_n),
    .irq_n     (irq_n),
    .cpu_ce    (cpu_ce),
    .lock_done (lock_done),
    .div_state (div_state),
    .lock_cnt  (lock_cnt)
);

// File: tb/clk_mode_ctrl_tb_top.sv
module clk_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ref_tick;
    logic [1:0] mode_sel = 2'b11;
    logic       rst_pin_n = 1'b0;
    logic [3:0] irq_n = 4'hF;
    logic       div_load = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       cpu_ce;
    logic       lock_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [2:0] ref_ph = 3'd0;
    int model_ticks = 0;
    bit lock_watch = 1'b0;
    int lock_mism = 0;

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  sel;
        logic [15:0] win;
        logic [15:0] exp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{mode: 2'b10, sel: 2'b00, win: 16'd100, exp: 16'd20},
        '{mode: 2'b00, sel: 2'b00, win: 16'd100, exp: 16'd20},
        '{mode: 2'b01, sel: 2'b00, win: 16'd100, exp: 16'd10},
        '{mode: 2'b11, sel: 2'b00, win: 16'd100, exp: 16'd100},
        '{mode: 2'b11, sel: 2'b01, win: 16'd160, exp: 16'd10},
        '{mode: 2'b10, sel: 2'b01, win: 16'd160, exp: 16'd2},
        '{mode: 2'b01, sel: 2'b01, win: 16'd320, exp: 16'd2}
    };

    clk_mode_ctrl dut_i (
        .clk       (clk),
        .por_n     (por_n),
        .ref_tick  (ref_tick),
        .mode_sel  (mode_sel),
        .rst_pin_n (rst_pin_n),
        .irq_n     (irq_n),
        .div_load  (div_load),
        .div_sel   (div_sel),
        .cpu_ce    (cpu_ce),
        .lock_done (lock_done)
    );

    always #5 clk = ~clk;

    // Reference strobe: one cycle in five, changed on the falling edge.
    always @(negedge clk) ref_ph <= (ref_ph == 3'd4) ? 3'd0 : ref_ph + 3'd1;
    assign ref_tick = (ref_ph == 3'd4);

    // Model of the lock count, built from R4 only.
    always @(posedge clk) begin
        if (por_n && ref_tick && rst_pin_n && mode_sel == 2'b11 && model_ticks < 256)
            model_ticks <= model_ticks + 1;
    end

    always @(negedge clk) begin
        if (lock_watch && (lock_done !== (model_ticks >= 256)))
            lock_mism <= lock_mism + 1;
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic count_ce(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu_ce) c++;
        end
    endtask

    task automatic load_div(input logic [1:0] sel);
        @(negedge clk);
        div_sel  = sel;
        div_load = 1'b1;
        @(negedge clk);
        div_load = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drop_after_tick();
        do @(posedge clk); while (ref_tick !== 1'b1);
        @(negedge clk);
        rst_pin_n = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        // Reset state (R4: lock status clear out of power-on reset)
        wait_cycles(5);
        check_eq("R4 reset cpu_ce", int'(cpu_ce), 0);
        check_eq("R4 reset lock_done", int'(lock_done), 0);
        @(negedge clk);
        por_n = 1'b1;
        lock_watch = 1'b1;

        // R4: no counting while device reset is low
        wait_cycles(1500);
        check_eq("R4 held in reset", int'(lock_done), 0);

        // R3: half reference rate before lock
        rst_pin_n = 1'b1;
        wait_cycles(20);
        count_ce(100, c);
        check_eq("R3 pre-lock rate", c, 10);

        // R4: lock completes on the 256th counted strobe
        for (int i = 0; i < 3000 && !lock_done; i++) @(negedge clk);
        wait_cycles(3);
        lock_watch = 1'b0;
        check_eq("R4 lock_done set", int'(lock_done), 1);
        check_eq("R4 lock timing mismatches", lock_mism, 0);

        // R5: fast source after lock
        wait_cycles(30);
        count_ce(50, c);
        check_eq("R5 fast rate", c, 50);

        // R6: sticky lock across a device reset
        rst_pin_n = 1'b0;
        wait_cycles(10);
        check_eq("R6 lock kept in reset", int'(lock_done), 1);
        rst_pin_n = 1'b1;
        count_ce(50, c);
        check_eq("R6 fast right after reset", c, 50);

        // Vector table: source modes crossed with divider settings
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            mode_sel = VECS[v].mode;
            load_div(VECS[v].sel);
            wait_cycles(400);
            count_ce(int'(VECS[v].win), c);
            check_eq($sformatf("table vector %0d (R1 R2 R5 R7)", v), c, int'(VECS[v].exp));
        end
        load_div(2'b00);
        @(negedge clk);
        mode_sel = 2'b11;
        wait_cycles(400);

        // R8: leaving one-sixteenth waits for the period in progress
        load_div(2'b01);
        wait_cycles(40);
        do @(negedge clk); while (cpu_ce !== 1'b1);
        div_sel  = 2'b00;
        div_load = 1'b1;
        @(negedge clk);
        div_load = 1'b0;
        c = int'(cpu_ce);
        begin
            int c2;
            count_ce(14, c2);
            c += c2;
        end
        check_eq("R8 no early change", c, 0);
        count_ce(10, c);
        check_eq("R8 full after boundary", c, 10);

        // R12: reserved code ignored
        load_div(2'b11);
        wait_cycles(5);
        count_ce(50, c);
        check_eq("R12 reserved select", c, 50);

        // R9 / R10: stop, then wake on an interrupt line
        load_div(2'b10);
        wait_cycles(5);
        count_ce(100, c);
        check_eq("R9 stop quiet", c, 0);
        load_div(2'b00);
        wait_cycles(3);
        count_ce(20, c);
        check_eq("R12 load ignored in stop", c, 0);
        irq_n[2] = 1'b0;
        wait_cycles(2);
        irq_n[2] = 1'b1;
        wait_cycles(3);
        count_ce(50, c);
        check_eq("R10 wake on interrupt", c, 50);

        // R11: wake from stop on device reset
        load_div(2'b10);
        wait_cycles(5);
        rst_pin_n = 1'b0;
        wait_cycles(2);
        rst_pin_n = 1'b1;
        wait_cycles(3);
        count_ce(50, c);
        check_eq("R11 wake on reset", c, 50);

        // R11: reset forces full speed and ignores loads while low
        load_div(2'b01);
        wait_cycles(40);
        rst_pin_n = 1'b0;
        load_div(2'b01);
        wait_cycles(2);
        rst_pin_n = 1'b1;
        wait_cycles(2);
        count_ce(48, c);
        check_eq("R11 full after reset, load ignored", c, 48);

        // R2: halved clock realigned by a falling reset, two starting phases
        @(negedge clk);
        mode_sel = 2'b01;
        wait_cycles(20);
        for (int t = 0; t < 2; t++) begin
            drop_after_tick();
            count_ce(9, c);
            check_eq($sformatf("R2 first strobe silent, trial %0d", t), c, 0);
            count_ce(3, c);
            check_eq($sformatf("R2 second strobe pulses, trial %0d", t), c, 1);
            rst_pin_n = 1'b1;
        end

        // R1: pass-through again after all of the above
        @(negedge clk);
        mode_sel = 2'b00;
        wait_cycles(20);
        count_ce(50, c);
        check_eq("R1 static pass-through", c, 10);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule